// File: doc/BRIEF.md
# Framed SPI Controller

This block is a 16-bit serial shift engine that moves words over SPI in framed form. A frame-sync pulse that lasts one SCK period marks the start of each word. There is no select line held low for the length of the word. Two independent mode inputs set the roles of the pins. One chooses whether the block drives SCK or follows an SCK from outside. The other chooses whether the block generates the frame-sync pulse or waits for one. Together they give four mode combinations.

Software-side logic writes a transmit word into a holding register through a one-cycle write strobe. It collects received words from a buffer that carries a full flag and an overflow flag. When the block is clock master, it divides the system clock to make SCK. SCK then runs continuously for as long as the block is enabled. In every mode, each launch edge and each sample edge is handled in the system clock domain. The external SCK, SDI and frame-sync inputs pass through two-flop synchronizers before that point.

Top module: `framed_spi_ctrl`

## Requirements
- R1: With clk_mst_i=1, sck_oe_o is 1 and sck_o toggles every div_i+1 system cycles while en_i is high. The first toggle leaves the cpol_i level. While en_i is low, sck_o rests at cpol_i. With clk_mst_i=0, sck_oe_o is 0 and SCK is taken from sck_i.
- R2: fs_oe_o equals fs_mst_i. The block drives fs_o only in frame-master mode. In frame-slave mode it uses fs_i.
- R3: The launch edge is the SCK transition away from the cpol_i level: rising when cpol_i=0, falling when cpol_i=1. sdo_o and fs_o change only on launch edges. sdi_i is sampled on the opposite edge.
- R4: In frame-master mode, a wr_i strobe raises fs_o (active high) at the next launch edge that finds the block idle. fs_o stays high for exactly one SCK period. Without a write, no pulse is generated.
- R5: At the launch edge that ends the frame pulse, the holding register is copied into the shift register. The first of its 16 bits goes out on sdo_o at that same edge, MSB first.
- R6: In frame-slave mode, when fs_i is sampled high on a sample edge, the transfer starts at the next launch edge.
- R7: A received frame pulse starts a transfer even when no write has occurred since the previous transfer. In that case the previous holding-register contents are sent again.
- R8: 16 bits are sampled from sdi_i, MSB first. After the 16th sample, the word appears on rdata_o and rx_full_o is set. rd_i clears rx_full_o and rx_ovf_o.
- R9: If a word completes while rx_full_o is still set, rx_ovf_o is set and rdata_o keeps the older word.
- R10: tx_empty_o is 1 after reset and becomes 1 when the holding register is copied into the shift register. It reads 0 from the cycle after a wr_i strobe.
- R11: After reset, rx_full_o=0, rx_ovf_o=0, tx_empty_o=1, fs_o=0 and sdo_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables SCK generation and framing |
| clk_mst_i | input | 1 | 1: block drives SCK; 0: SCK comes from sck_i |
| fs_mst_i | input | 1 | 1: block generates frame sync; 0: frame sync comes from fs_i |
| cpol_i | input | 1 | SCK idle level and edge selection |
| div_i | input | DIV_W | SCK half period minus one, in system cycles |
| wr_i | input | 1 | Write strobe for the transmit holding register |
| wdata_i | input | WORD_W | Transmit word |
| rd_i | input | 1 | Read strobe; clears the full and overflow flags |
| rdata_o | output | WORD_W | Last accepted received word |
| rx_full_o | output | 1 | Received word waiting |
| rx_ovf_o | output | 1 | A word was dropped while the buffer was full |
| tx_empty_o | output | 1 | Holding register has been moved to the shifter |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | Output enable for the SCK pad |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Generated frame sync |
| fs_oe_o | output | 1 | Output enable for the frame-sync pad |

## Verification
In clock-master mode, sck_o, sdo_o and fs_o all change on the same system edge, so the bench compares them against its own model on every falling system edge. In clock-slave mode, the block's responses trail the bench's SCK edges by three system cycles: two synchronizer stages plus one register. The bench's SCK half period of eight cycles therefore leaves a wide margin. rx_full_o and rdata_o settle one cycle after the block's 16th sample edge, and tx_empty_o falls one cycle after a write. Buffer and flag checks are therefore taken several cycles after the bench peer has captured the last bit of a word.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef struct packed {
    logic launch;   // SCK edge on which outputs move
    logic capture;  // SCK edge on which inputs are sampled
  } sck_edge_t;
endpackage

// File: rtl/fspi_sync.sv
module fspi_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/fspi_clk_gen.sv
module fspi_clk_gen
  import fspi_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clk_mst_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sck_s_i,
  output logic             sck_o,
  output sck_edge_t        edges_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q, sck_prev_q;
  logic             run, tick, slv_edge;

  assign run = en_i & clk_mst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s_i;
      if (!run) begin
        cnt_q <= '0;
        sck_q <= cpol_i;
      end else if (cnt_q == div_i) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  always_comb begin
    tick     = run && (cnt_q == div_i);
    slv_edge = en_i && !clk_mst_i && (sck_s_i != sck_prev_q);
    if (clk_mst_i) begin
      edges_o.launch  = tick && (sck_q == cpol_i);
      edges_o.capture = tick && (sck_q != cpol_i);
    end else begin
      edges_o.launch  = slv_edge && (sck_s_i != cpol_i);
      edges_o.capture = slv_edge && (sck_s_i == cpol_i);
    end
  end

  assign sck_o = sck_q;

  AST_LAUNCH_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_mst_i && edges_o.launch) |=> (sck_o != $past(cpol_i))); // R3
  AST_SCK_RESTS_AT_CPOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && clk_mst_i) |=> (sck_o == $past(cpol_i))); // R1
endmodule

// File: rtl/fspi_core.sv
module fspi_core
  import fspi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         fs_mst_i,
  input  sck_edge_t    edges_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  input  logic         sdi_s_i,
  input  logic         fs_s_i,
  output logic         sdo_o,
  output logic         fs_o,
  output logic [W-1:0] rdata_o,
  output logic         rx_full_o,
  output logic         rx_ovf_o,
  output logic         tx_empty_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hold_q, tx_sh_q, rbuf_q;
  logic [W-2:0]  rx_sh_q;
  logic [CW-1:0] cnt_q;
  logic          active_q, pend_q, fs_q, seen_q, full_q, ovf_q, empty_q;
  logic          start, done;
  logic [W-1:0]  rx_word;

  assign rx_word = {rx_sh_q, sdi_s_i};

  always_comb begin
    start = edges_i.launch && (fs_mst_i ? fs_q : seen_q);
    done  = edges_i.capture && active_q && (cnt_q == CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      rbuf_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      fs_q     <= 1'b0;
      seen_q   <= 1'b0;
      full_q   <= 1'b0;
      ovf_q    <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (!en_i) begin
        active_q <= 1'b0;
        fs_q     <= 1'b0;
        seen_q   <= 1'b0;
      end else begin
        if (start) begin
          tx_sh_q  <= hold_q;
          active_q <= 1'b1;
          cnt_q    <= CW'(W);
          fs_q     <= 1'b0;
          seen_q   <= 1'b0;
          pend_q   <= 1'b0;
          empty_q  <= 1'b1;
        end else if (edges_i.launch) begin
          if (active_q) tx_sh_q <= tx_sh_q << 1;
          else if (fs_mst_i && pend_q && !fs_q) begin
            fs_q   <= 1'b1;
            pend_q <= 1'b0;
          end
        end
        if (edges_i.capture) begin
          if (!fs_mst_i && fs_s_i) seen_q <= 1'b1;
          if (active_q) begin
            rx_sh_q <= rx_word[W-2:0];
            cnt_q   <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) active_q <= 1'b0;
          end
        end
      end
      // write wins over a same-cycle load
      if (wr_i) begin
        hold_q  <= wdata_i;
        pend_q  <= 1'b1;
        empty_q <= 1'b0;
      end
      if (rd_i) begin
        full_q <= 1'b0;
        ovf_q  <= 1'b0;
      end
      if (done) begin
        if (full_q && !rd_i) ovf_q <= 1'b1;
        else begin
          rbuf_q <= rx_word;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign sdo_o      = tx_sh_q[W-1];
  assign fs_o       = fs_q;
  assign rdata_o    = rbuf_q;
  assign rx_full_o  = full_q;
  assign rx_ovf_o   = ovf_q;
  assign tx_empty_o = empty_q;

  AST_SDO_AT_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(edges_i.launch)); // R3
  AST_FS_AT_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_q) |-> $past(edges_i.launch)); // R3
  AST_FS_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q && edges_i.launch) |=> !fs_q); // R4
  AST_EMPTY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !wr_i) |=> empty_q); // R10
  AST_FULL_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> full_q); // R8
  AST_OVF_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && full_q && !rd_i) |=> (ovf_q && $stable(rbuf_q))); // R9
endmodule

// File: rtl/framed_spi_ctrl.sv
module framed_spi_ctrl
  import fspi_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clk_mst_i,
  input  logic              fs_mst_i,
  input  logic              cpol_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rx_full_o,
  output logic              rx_ovf_o,
  output logic              tx_empty_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              fs_i,
  output logic              fs_o,
  output logic              fs_oe_o
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] sync_q;
  sck_edge_t         edges;

  fspi_sync #(.W(N_SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sdi_i, fs_i}),
    .q_o   (sync_q)
  );

  fspi_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .clk_mst_i(clk_mst_i),
    .cpol_i   (cpol_i),
    .div_i    (div_i),
    .sck_s_i  (sync_q[2]),
    .sck_o    (sck_o),
    .edges_o  (edges)
  );

  fspi_core #(.W(WORD_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .fs_mst_i  (fs_mst_i),
    .edges_i   (edges),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rd_i      (rd_i),
    .sdi_s_i   (sync_q[1]),
    .fs_s_i    (sync_q[0]),
    .sdo_o     (sdo_o),
    .fs_o      (fs_o),
    .rdata_o   (rdata_o),
    .rx_full_o (rx_full_o),
    .rx_ovf_o  (rx_ovf_o),
    .tx_empty_o(tx_empty_o)
  );

  assign sck_oe_o = clk_mst_i;
  assign fs_oe_o  = fs_mst_i;
endmodule

// File: tb/framed_spi_ctrl_tb.sv
module framed_spi_ctrl_tb;
  localparam int HB = 8;          // bench SCK half period in system cycles
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;          // 50 MHz

  logic        en = 0, clk_mst = 0, fs_mst = 0, cpol = 0, wr = 0, rd = 0;
  logic [7:0]  div = 8'd3;
  logic [15:0] wdata = '0;
  logic [15:0] peer_tx = '0;
  int          fs_req_cnt = 0;

  logic        sck_b = 0, sdi_b = 0, fs_b = 0;
  logic [15:0] rdata;
  logic        rx_full, rx_ovf, tx_empty, sck_o, sck_oe, sdo, fs_o, fs_oe;

  framed_spi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clk_mst_i(clk_mst), .fs_mst_i(fs_mst),
    .cpol_i(cpol), .div_i(div), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .rx_full_o(rx_full), .rx_ovf_o(rx_ovf), .tx_empty_o(tx_empty),
    .sck_i(sck_b), .sck_o(sck_o), .sck_oe_o(sck_oe), .sdi_i(sdi_b), .sdo_o(sdo),
    .fs_i(fs_b), .fs_o(fs_o), .fs_oe_o(fs_oe)
  );

  int checks = 0, fails = 0;
  int clk_checks = 0, clk_fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // posedges seen with the SCK generator running
  int m = 0;
  always @(posedge clk) m <= (en && clk_mst) ? m + 1 : 0;

  // peer model and per-clock checks
  logic [15:0] got_q[$];
  logic [15:0] p_rx = '0;
  int  p_idx = 0, hcnt = 0, fs_served = 0, cyc = 0;
  bit  p_active = 0, p_go = 0, fs_at_launch = 0;
  logic line, line_prev = 0, sdo_prev = 0, fs_prev = 0, exp_sck;
  bit  lau, cap, fsl;

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      clk_fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + clk_checks + 1, fails + clk_fails);
      $finish;
    end
    if (!en || clk_mst) begin
      sck_b = cpol;
      hcnt  = 0;
    end else begin
      hcnt++;
      if (hcnt == HB) begin
        hcnt  = 0;
        sck_b = ~sck_b;
      end
    end
    line = clk_mst ? sck_o : sck_b;
    lau  = en && (line != line_prev) && (line != cpol);
    cap  = en && (line != line_prev) && (line == cpol);
    fsl  = fs_mst ? fs_o : fs_b;

    if (rst_n) begin
      // R1 R2: pad directions follow the mode inputs
      clk_checks++;
      if (sck_oe !== clk_mst || fs_oe !== fs_mst) begin
        clk_fails++;
        $display("FAIL R1/R2 oe actual=%0b%0b expected=%0b%0b", sck_oe, fs_oe, clk_mst, fs_mst);
      end
      if (en && clk_mst) begin
        exp_sck = cpol ^ logic'((m / (int'(div) + 1)) % 2);
        clk_checks++;
        if (sck_o !== exp_sck) begin
          clk_fails++;
          $display("FAIL R1 sck_o actual=%0b expected=%0b", sck_o, exp_sck);
        end
        clk_checks++;
        if (sdo !== sdo_prev && !lau) begin
          clk_fails++;
          $display("FAIL R3 sdo moved off launch edge actual=%0b expected=%0b", sdo, sdo_prev);
        end
        if (fs_mst) begin
          clk_checks++;
          if (fs_o !== fs_prev && !lau) begin
            clk_fails++;
            $display("FAIL R3 fs_o moved off launch edge actual=%0b expected=%0b", fs_o, fs_prev);
          end
        end
      end
    end

    if (!en) begin
      p_active     = 0;
      p_go         = 0;
      fs_b         = 0;
      fs_at_launch = 0;
      fs_served    = fs_req_cnt;
    end else begin
      if (cap) begin
        if (fsl && !p_active) p_go = 1;
        if (p_active) begin
          p_rx = {p_rx[14:0], sdo};
          if (p_idx == 0) begin
            p_active = 0;
            got_q.push_back(p_rx);
          end else p_idx--;
        end
      end
      if (lau) begin
        if (p_go) begin
          p_go = 0;
          p_active = 1;
          p_idx = 15;
        end
        if (p_active) sdi_b = peer_tx[p_idx];
        if (fs_b) fs_b = 0;
        else if (!fs_mst && fs_served != fs_req_cnt) begin
          fs_b = 1;
          fs_served++;
        end
        if (clk_mst && fs_mst) begin
          if (fs_at_launch) begin
            clk_checks++;
            if (fs_o !== 1'b0) begin
              clk_fails++;
              $display("FAIL R4 fs_o pulse longer than one period actual=%0b expected=0", fs_o);
            end
          end
          fs_at_launch = fs_o;
        end
      end
    end
    line_prev = line;
    sdo_prev  = sdo;
    fs_prev   = fs_o;
  end

  task automatic setup(input logic cm, input logic fm, input logic pol, input logic [7:0] d);
    @(posedge clk); #2 en = 0;
    repeat (4) @(posedge clk);
    #2 clk_mst = cm; fs_mst = fm; cpol = pol; div = d;
    repeat (4) @(posedge clk);
    #2 en = 1;
  endtask

  task automatic write_word(input logic [15:0] v);
    @(posedge clk); #2 wr = 1; wdata = v;
    @(posedge clk); #2 wr = 0;
  endtask

  task automatic read_word();
    @(posedge clk); #2 rd = 1;
    @(posedge clk); #2 rd = 0;
  endtask

  task automatic request_fs();
    @(posedge clk); #2 fs_req_cnt++;
  endtask

  task automatic wait_frames(input int n, input string tag);
    int k = 0;
    while (got_q.size() < n && k < 20000) begin
      @(posedge clk);
      k++;
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(got_q.size() >= n, {tag, " frame count"}, got_q.size(), n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(rx_full == 0, "R11 rx_full", rx_full, 0);
    chk(rx_ovf == 0, "R11 rx_ovf", rx_ovf, 0);
    chk(tx_empty == 1, "R11 tx_empty", tx_empty, 1);
    chk(fs_o == 0 && sdo == 0, "R11 fs_o/sdo", {fs_o, sdo}, 0);

    // clock master, frame master, cpol 0
    setup(1, 1, 0, 8'd3);
    peer_tx = 16'h3C5A;
    write_word(16'hA5C3);
    @(negedge clk);
    chk(tx_empty == 0, "R10 tx_empty after write", tx_empty, 0);
    wait_frames(1, "R4");
    chk(got_q[0] == 16'hA5C3, "R5 word on sdo", got_q[0], 16'hA5C3);
    chk(rdata == 16'h3C5A, "R8 rdata", rdata, 16'h3C5A);
    chk(rx_full == 1, "R8 rx_full", rx_full, 1);
    chk(tx_empty == 1, "R10 tx_empty after load", tx_empty, 1);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(got_q.size() == 1, "R4 no pulse without write", got_q.size(), 1);

    // overflow: second word while unread
    peer_tx = 16'h1111;
    write_word(16'h1234);
    wait_frames(2, "R9");
    chk(got_q[1] == 16'h1234, "R5 second word", got_q[1], 16'h1234);
    chk(rx_ovf == 1, "R9 rx_ovf", rx_ovf, 1);
    chk(rdata == 16'h3C5A, "R9 old data kept", rdata, 16'h3C5A);
    read_word();
    @(negedge clk);
    chk(rx_full == 0 && rx_ovf == 0, "R8 read clears flags", {rx_full, rx_ovf}, 0);

    // clock slave, frame slave, cpol 1
    setup(0, 0, 1, 8'd3);
    write_word(16'hC001);
    peer_tx = 16'h8421;
    request_fs();
    wait_frames(3, "R6");
    chk(got_q[2] == 16'hC001, "R6 slave frame word", got_q[2], 16'hC001);
    chk(rdata == 16'h8421, "R8 rdata slave clock", rdata, 16'h8421);
    read_word();
    peer_tx = 16'h0FF0;
    request_fs();
    wait_frames(4, "R7");
    chk(got_q[3] == 16'hC001, "R7 old word resent", got_q[3], 16'hC001);
    chk(rdata == 16'h0FF0, "R8 rdata second slave word", rdata, 16'h0FF0);
    chk(tx_empty == 1, "R10 tx_empty stays set", tx_empty, 1);
    read_word();

    // clock master, frame slave, cpol 1
    setup(1, 0, 1, 8'd5);
    write_word(16'h0F0F);
    peer_tx = 16'hF00D;
    request_fs();
    wait_frames(5, "R6");
    chk(got_q[4] == 16'h0F0F, "R6 master clock, external sync", got_q[4], 16'h0F0F);
    chk(rdata == 16'hF00D, "R8 rdata cpol1", rdata, 16'hF00D);
    read_word();

    // clock slave, frame master, cpol 0
    setup(0, 1, 0, 8'd3);
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk(got_q.size() == 5, "R4 idle without write", got_q.size(), 5);
    chk(fs_o == 0, "R4 fs_o idle", fs_o, 0);
    peer_tx = 16'h1357;
    write_word(16'h7E81);
    wait_frames(6, "R4");
    chk(got_q[5] == 16'h7E81, "R5 slave clock frame master", got_q[5], 16'h7E81);
    chk(rdata == 16'h1357, "R8 rdata", rdata, 16'h1357);
    read_word();

    // back-to-back frames, cpol 1, short divider
    setup(1, 1, 1, 8'd2);
    peer_tx = 16'h5AA5;
    write_word(16'h1111);
    begin
      int k = 0;
      @(negedge clk);
      while (!tx_empty && k < 5000) begin
        @(negedge clk);
        k++;
      end
    end
    write_word(16'h2222);
    wait_frames(8, "R5");
    chk(got_q[6] == 16'h1111, "R5 first of pair", got_q[6], 16'h1111);
    chk(got_q[7] == 16'h2222, "R5 second of pair", got_q[7], 16'h2222);
    chk(rx_ovf == 1, "R9 overflow on pair", rx_ovf, 1);
    chk(rdata == 16'h5AA5, "R9 first word kept", rdata, 16'h5AA5);

    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + clk_checks, fails + clk_fails);
    $finish;
  end
endmodule